// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block keeps the address state of one DMA channel. It holds a source address, a destination address and a transfer counter, and it advances them after each completed dual-address transfer. The bus cycles themselves, channel arbitration and bank decoding happen outside. The surrounding controller writes start values through load strobes. It then sends one `xfer_done` pulse per finished transfer and reads back the addresses for the next transfer and the remaining count.

The source and the destination each have their own addressing mode. A fixed address never moves. An incrementing address advances by the data size. A ring-buffered address advances by the data size and returns to its loaded start after a selectable number of transfers. Every address update stays inside its bank: only the low `BANK_W` bits can change. The counter counts down once per transfer. It raises a one-cycle `underflow` pulse on the transfer that takes it below zero, so a loaded value C gives C+1 transfers.

The block moves no data stream, so it has no valid/ready handshake and nothing to throttle. Every pin is a plain level or a plain strobe, and a strobe acts in the cycle it is sampled.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `src_addr`, `dst_addr` and `count` read 0 and `underflow` is low.
- R2: A load strobe (`src_load`, `dst_load`, `cnt_load`) writes its value into its own register, and the new value appears on the output one clock later. The other registers are not touched by that strobe.
- R3: When a load strobe and `xfer_done` arrive in the same cycle, the load wins for that register. The registers without a load still take the transfer update. A count load in that cycle produces no `underflow`.
- R4: Mode encoding per side: 0 = fixed, 1 = increment, 2 = ring, 3 = fixed. In fixed mode a transfer leaves the address unchanged.
- R5: In increment mode each transfer adds 1 when `cfg_size` is 0 (8-bit data) and 2 when `cfg_size` is 1 (16-bit data).
- R6: In ring mode, `ring_sel` codes 0, 1, 2, 3 and 4 select a length of 2, 4, 8, 16 and 32 transfers; codes 5 to 7 select 32. Each transfer adds the data size, except that the transfer which completes the length returns the address to the last loaded value. A load restarts the position in the ring.
- R7: Transfer updates never change address bits `AW-1` down to `BANK_W`. The low `BANK_W` bits wrap modulo 2^`BANK_W`.
- R8: Each `xfer_done` without a count load lowers `count` by one. Without `xfer_done` or a load, `count` and both addresses hold, whatever the modes.
- R9: `underflow` is high for exactly the one cycle after a transfer taken at count 0, and `count` then reads 0xFFFF. Loading C produces the pulse on transfer C+1, so loading 0xFFFF gives 65,536 transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 1 | Data size: 0 = 8-bit, 1 = 16-bit |
| src_mode | input | 2 | Source addressing mode |
| dst_mode | input | 2 | Destination addressing mode |
| ring_sel | input | 3 | Ring length code, shared by both sides |
| src_load | input | 1 | Load strobe for the source address |
| src_load_val | input | AW | Source start address |
| dst_load | input | 1 | Load strobe for the destination address |
| dst_load_val | input | AW | Destination start address |
| cnt_load | input | 1 | Load strobe for the counter |
| cnt_load_val | input | CW | Counter start value |
| xfer_done | input | 1 | One pulse per completed transfer |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| count | output | CW | Remaining count |
| underflow | output | 1 | One-cycle pulse when the counter passes zero |

## Verification
The checker watches a set of rules on every cycle:
- the counter holds or steps by exactly one, and a count load lands one cycle later;
- an underflow pulse always follows a transfer taken at zero and shows 0xFFFF;
- the bank bits never move without a load;
- a fixed address holds across a transfer;
- an incrementing address moves by the data size.

Other behaviour spans many cycles, so only the bench scenarios can show it: the ring returning to the loaded address after each selectable length, the position restarting on a reload, load-versus-transfer precedence on one side while the other side advances, and the full 65,536-transfer run with its single pulse.

// File: rtl/dag_pkg.sv
package dag_pkg;

  localparam logic [1:0] MODE_FIXED = 2'd0;
  localparam logic [1:0] MODE_INCR  = 2'd1;
  localparam logic [1:0] MODE_RING  = 2'd2;

  localparam int RING_POS_W = 5;

  // Last position in the ring for a length code; codes above 4 select 32.
  function automatic logic [RING_POS_W-1:0] ring_last(input logic [2:0] sel);
    logic [RING_POS_W-1:0] r;
    case (sel)
      3'd0:    r = 5'd1;
      3'd1:    r = 5'd3;
      3'd2:    r = 5'd7;
      3'd3:    r = 5'd15;
      default: r = 5'd31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dag_addr_unit.sv
module dag_addr_unit
  import dag_pkg::*;
#(
  parameter int AW     = 20,
  parameter int BANK_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          size16,
  input  logic [2:0]    ring_sel,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          done,
  output logic [AW-1:0] addr
);

  localparam int HI_W = AW - BANK_W;

  logic [AW-1:0]         cur_q, base_q;
  logic [RING_POS_W-1:0] pos_q;
  logic [BANK_W-1:0]     step;
  logic [BANK_W-1:0]     low_next;
  logic [AW-1:0]         stepped;
  logic                  ring_end;

  assign step     = size16 ? BANK_W'(2) : BANK_W'(1);
  assign low_next = cur_q[BANK_W-1:0] + step;

  generate
    if (HI_W > 0) begin : g_bank
      assign stepped = {cur_q[AW-1:BANK_W], low_next};
    end else begin : g_flat
      assign stepped = low_next;
    end
  endgenerate

  assign ring_end = (pos_q == ring_last(ring_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
      pos_q  <= '0;
    end else if (load) begin
      cur_q  <= load_val;
      base_q <= load_val;
      pos_q  <= '0;
    end else if (done) begin
      case (mode)
        MODE_INCR: cur_q <= stepped;
        MODE_RING: begin
          if (ring_end) begin
            cur_q <= base_q;
            pos_q <= '0;
          end else begin
            cur_q <= stepped;
            pos_q <= pos_q + 1'b1;
          end
        end
        default: cur_q <= cur_q;
      endcase
    end
  end

  assign addr = cur_q;

endmodule

// File: rtl/dag_counter.sv
module dag_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          done,
  output logic [CW-1:0] count,
  output logic          underflow
);

  logic [CW-1:0] cnt_q;
  logic          uf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (done) begin
        cnt_q <= cnt_q - 1'b1;
        uf_q  <= (cnt_q == '0);
      end
    end
  end

  assign count     = cnt_q;
  assign underflow = uf_q;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW     = 20,
  parameter int BANK_W = 16,
  parameter int CW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_size,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [2:0]    ring_sel,
  input  logic          src_load,
  input  logic [AW-1:0] src_load_val,
  input  logic          dst_load,
  input  logic [AW-1:0] dst_load_val,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_load_val,
  input  logic          xfer_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] count,
  output logic          underflow
);

  localparam int SIDES = 2;

  logic [1:0]    side_mode [SIDES];
  logic          side_load [SIDES];
  logic [AW-1:0] side_val  [SIDES];
  logic [AW-1:0] side_addr [SIDES];

  assign side_mode[0] = src_mode;
  assign side_mode[1] = dst_mode;
  assign side_load[0] = src_load;
  assign side_load[1] = dst_load;
  assign side_val[0]  = src_load_val;
  assign side_val[1]  = dst_load_val;

  generate
    for (genvar g = 0; g < SIDES; g++) begin : g_side
      dag_addr_unit #(.AW(AW), .BANK_W(BANK_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (side_mode[g]),
        .size16   (cfg_size),
        .ring_sel (ring_sel),
        .load     (side_load[g]),
        .load_val (side_val[g]),
        .done     (xfer_done),
        .addr     (side_addr[g])
      );
    end
  endgenerate

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];

  dag_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_load),
    .load_val  (cnt_load_val),
    .done      (xfer_done),
    .count     (count),
    .underflow (underflow)
  );

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
  parameter int AW     = 20,
  parameter int BANK_W = 16,
  parameter int CW     = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_size,
  input logic [1:0]    src_mode,
  input logic [1:0]    dst_mode,
  input logic          src_load,
  input logic          dst_load,
  input logic          cnt_load,
  input logic [CW-1:0] cnt_load_val,
  input logic          xfer_done,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] count,
  input logic          underflow
);

  assert_uf_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (count == {CW{1'b1}}));

  assert_uf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> ($past(xfer_done) && !$past(cnt_load) && ($past(count) == '0)));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done && !cnt_load) |=> $stable(count));

  assert_count_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (count == $past(cnt_load_val)));

  assert_bank_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_load |=> $stable(src_addr[AW-1:BANK_W]));

  assert_bank_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_load |=> $stable(dst_addr[AW-1:BANK_W]));

  assert_fixed_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !src_load && (src_mode == 2'd0 || src_mode == 2'd3)) |=> $stable(src_addr));

  assert_incr_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !dst_load && dst_mode == 2'd1) |=>
      (dst_addr[BANK_W-1:0] == BANK_W'($past(dst_addr[BANK_W-1:0]) + ($past(cfg_size) ? 2 : 1))));

endmodule

bind dma_addr_gen dag_checker #(.AW(AW), .BANK_W(BANK_W), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_size     (cfg_size),
  .src_mode     (src_mode),
  .dst_mode     (dst_mode),
  .src_load     (src_load),
  .dst_load     (dst_load),
  .cnt_load     (cnt_load),
  .cnt_load_val (cnt_load_val),
  .xfer_done    (xfer_done),
  .src_addr     (src_addr),
  .dst_addr     (dst_addr),
  .count        (count),
  .underflow    (underflow)
);

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
  localparam int PERIOD = 10;
  localparam int AW = 20;
  localparam int BW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_size = 1'b0;
  logic [1:0]    src_mode = 2'd0, dst_mode = 2'd0;
  logic [2:0]    ring_sel = 3'd0;
  logic          src_load = 1'b0, dst_load = 1'b0, cnt_load = 1'b0;
  logic [AW-1:0] src_load_val = '0, dst_load_val = '0;
  logic [CW-1:0] cnt_load_val = '0;
  logic          xfer_done = 1'b0;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] count;
  logic          underflow;

  int checks = 0;
  int errors = 0;

  typedef logic [AW+AW+CW:0] exp_t;
  exp_t  q_exp[$];
  string q_tag[$];

  logic [AW-1:0] m_cur [2];
  logic [AW-1:0] m_base[2];
  int            m_pos [2];
  logic [CW-1:0] m_cnt;

  always #(PERIOD/2) clk = ~clk;

  dma_addr_gen #(.AW(AW), .BANK_W(BW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .src_mode(src_mode),
    .dst_mode(dst_mode), .ring_sel(ring_sel), .src_load(src_load),
    .src_load_val(src_load_val), .dst_load(dst_load), .dst_load_val(dst_load_val),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .xfer_done(xfer_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .count(count), .underflow(underflow)
  );

  function automatic int ring_len(input logic [2:0] sel);
    return (sel > 3'd4) ? 32 : (2 << sel);
  endfunction

  // Expected next address of one side (requirements R4..R7).
  task automatic model_side(input int s, input logic [1:0] md, input logic ld,
                            input logic [AW-1:0] v, input logic dn);
    logic [BW-1:0] lo;
    if (ld) begin
      m_cur[s] = v; m_base[s] = v; m_pos[s] = 0;
    end else if (dn) begin
      lo = m_cur[s][BW-1:0] + (cfg_size ? BW'(2) : BW'(1));
      if (md == 2'd1) begin
        m_cur[s][BW-1:0] = lo;
      end else if (md == 2'd2) begin
        if (m_pos[s] == ring_len(ring_sel) - 1) begin
          m_cur[s] = m_base[s]; m_pos[s] = 0;
        end else begin
          m_cur[s][BW-1:0] = lo; m_pos[s]++;
        end
      end
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic cyc(input logic dn, input logic ls, input logic [AW-1:0] sv,
                     input logic ld, input logic [AW-1:0] dv,
                     input logic lc, input logic [CW-1:0] cv, input string tag);
    logic uf;
    uf = 1'b0;
    model_side(0, src_mode, ls, sv, dn);
    model_side(1, dst_mode, ld, dv, dn);
    if (lc) m_cnt = cv;
    else if (dn) begin uf = (m_cnt == '0); m_cnt = m_cnt - 1'b1; end
    xfer_done = dn; src_load = ls; src_load_val = sv;
    dst_load = ld; dst_load_val = dv; cnt_load = lc; cnt_load_val = cv;
    q_exp.push_back({m_cur[0], m_cur[1], m_cnt, uf});
    q_tag.push_back(tag);
    @(negedge clk);
    xfer_done = 1'b0; src_load = 1'b0; dst_load = 1'b0; cnt_load = 1'b0;
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic load_all(input logic [AW-1:0] sv, input logic [AW-1:0] dv,
                          input logic [CW-1:0] cv, input string tag);
    cyc(1'b0, 1'b1, sv, 1'b1, dv, 1'b1, cv, tag);
  endtask

  // Monitor: pops expectations and compares shortly after each edge.
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = {src_addr, dst_addr, count, underflow};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s src=%h dst=%h cnt=%h uf=%b expected src=%h dst=%h cnt=%h uf=%b",
                 t, a[AW+AW+CW:AW+CW+1], a[AW+CW:CW+1], a[CW:1], a[0],
                 e[AW+AW+CW:AW+CW+1], e[AW+CW:CW+1], e[CW:1], e[0]);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_cur[0] = '0; m_cur[1] = '0; m_base[0] = '0; m_base[1] = '0;
    m_pos[0] = 0; m_pos[1] = 0; m_cnt = '0;
    repeat (3) @(negedge clk);
    checks++;
    if ({src_addr, dst_addr, count, underflow} !== '0) begin
      errors++;
      $display("FAIL R1 in reset src=%h dst=%h cnt=%h uf=%b expected all zero",
               src_addr, dst_addr, count, underflow);
    end
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R1 after reset");

    // Loads and idle hold, including increment mode without transfers
    load_all(20'h3_0010, 20'h5_0100, 16'd9, "R2 load all");
    src_mode = 2'd1; dst_mode = 2'd1;
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R8 idle hold");
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R8 idle hold");
    cyc(1'b0, 1'b0, '0, 1'b1, 20'h5_0400, 1'b0, '0, "R2 dst load only");

    // Increment vs fixed, both sizes, fixed code 3
    src_mode = 2'd1; dst_mode = 2'd0; cfg_size = 1'b0;
    steps(3, "R5 R4 incr8 src fixed dst");
    src_mode = 2'd3; dst_mode = 2'd1; cfg_size = 1'b1;
    steps(3, "R5 R4 incr16 dst code3 src");

    // Ring modes
    src_mode = 2'd2; dst_mode = 2'd2; cfg_size = 1'b1; ring_sel = 3'd1;
    load_all(20'h3_1000, 20'h5_2000, 16'hFFFF, "R6 ring load");
    steps(9, "R6 ring len4");
    ring_sel = 3'd0; cfg_size = 1'b0;
    load_all(20'h3_1000, 20'h5_2000, 16'hFFFF, "R6 ring reload");
    steps(5, "R6 ring len2");
    ring_sel = 3'd3;
    steps(1, "R6 ring len16 partial");
    cyc(1'b1, 1'b1, 20'h3_4000, 1'b0, '0, 1'b0, '0, "R6 R3 reload restarts");
    steps(17, "R6 ring len16");
    ring_sel = 3'd4;
    load_all(20'h3_1000, 20'h5_2000, 16'hFFFF, "R6 ring reload");
    steps(33, "R6 ring len32");
    ring_sel = 3'd7;
    load_all(20'h3_1000, 20'h5_2000, 16'hFFFF, "R6 ring reload");
    steps(33, "R6 ring code7");

    // Bank wrap
    src_mode = 2'd1; dst_mode = 2'd1; cfg_size = 1'b1;
    load_all(20'h3_FFFE, 20'h5_FFFF, 16'd100, "R7 bank load");
    steps(2, "R7 bank wrap");

    // Precedence: src load with transfer, others advance
    cyc(1'b1, 1'b1, 20'h3_0200, 1'b0, '0, 1'b0, '0, "R3 src load wins");
    cyc(1'b1, 1'b0, '0, 1'b1, 20'h5_0300, 1'b1, 16'd0, "R3 dst and cnt load win");
    cyc(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 16'd0, "R3 cnt load at zero no uf");

    // Underflow
    steps(1, "R9 uf from zero");
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R9 uf one cycle");
    load_all(20'h3_0000, 20'h5_0000, 16'd1, "R9 load one");
    steps(2, "R9 two transfers");
    load_all(20'h3_0000, 20'h5_0000, 16'hFFFF, "R9 load max");
    steps(65536, "R9 full count");
    cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R9 after full");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule